// File: doc/BRIEF.md
# Start-Bit Framed Synchronous Serial Receiver

This block turns a one-bit-per-clock serial stream into parallel bytes. Sender and receiver share the same clock, so no clock recovery or oversampling takes place. While the line is quiet it sits at logic 0. A frame opens with a single logic-1 start bit. The eight data bits follow, one per clock, lowest bit first. Once the last data bit is in, the receiver drives the assembled byte and raises a valid strobe for exactly one cycle. Any logic that consumes the byte must take it in that cycle.

There is no bit counter. The end of each frame is timed by a one-hot delay line that carries the start bit through nine stages. The delay line only accepts a new bit while the controller is idle. A tap one stage before the end lets the two-state controller return to idle one cycle early, so a new start bit placed directly after bit 7 is still caught. The serial input is registered once before it reaches the controller and the data shifter.

Top module: `start_framed_rx`

## Requirements
- R1: While the controller is idle, a logic 1 sampled on `serial_in` is taken as a start bit and opens a frame; with `serial_in` held at 0 and no frame in progress, `byte_valid` stays low.
- R2: The eight bits sampled on the eight rising edges after the start bit form the byte. The first of them appears in `byte_out[0]` and the last in `byte_out[7]`.
- R3: `byte_valid` is high in the cycle that follows the tenth rising edge, counting from and including the edge that samples the start bit. `byte_out` holds the complete byte in that cycle.
- R4: Data bits equal to 1 that arrive while a frame is in progress never open a new frame. At most one start bit is in flight in the delay line.
- R5: A start bit sampled on the edge directly after the one that samples data bit 7 is recognised. The valid strobes of back-to-back frames are exactly nine cycles apart.
- R6: `rst_n` is active low and synchronous, and it overrides every other update. It returns the controller to idle and clears the delay line, so `byte_valid` is low after any reset edge. A frame that is interrupted by reset produces no strobe.
- R7: `byte_valid` lasts exactly one cycle and is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock; one serial bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| serial_in | input | 1 | Serial line: idles at 0, start bit is a single 1 |
| byte_out | output | 8 | Assembled byte; valid only while `byte_valid` is high |
| byte_valid | output | 1 | One-cycle strobe marking a complete byte |

## Verification
The assertions assume that `serial_in` is a clean value that is stable around each rising edge, as it would be from a sender on the same clock. They also assume that the line returns to 0 between frames, unless a new start bit follows bit 7 at once. The stimulus changes `serial_in` only on falling edges. It builds every stream from idle zeros, start bits and whole data bytes. The one exception is a frame deliberately cut short by reset, and that frame is kept inside the reset window the assertions are disabled for.

// File: rtl/start_framed_rx_pkg.sv
package start_framed_rx_pkg;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_e;

  // Stages the start bit travels before the strobe: one per data bit plus one.
  function automatic int frame_stages(input int data_bits);
    return data_bits + 1;
  endfunction

  // Index of the look-ahead tap, one stage ahead of the strobe stage.
  function automatic int lookahead_tap(input int data_bits);
    return frame_stages(data_bits) - 2;
  endfunction

endpackage

// File: rtl/rx_line_reg.sv
module rx_line_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_in;
  end

endmodule

// File: rtl/rx_frame_delay.sv
module rx_frame_delay #(
  parameter int DATA_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inject,
  output logic near_end,
  output logic frame_end
);
  import start_framed_rx_pkg::*;

  localparam int STAGES = frame_stages(DATA_BITS);
  localparam int TAP    = lookahead_tap(DATA_BITS);

  logic [STAGES-1:0] stg;

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= 1'b0;
    else        stg[0] <= inject;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[i] <= 1'b0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign near_end  = stg[TAP];
  assign frame_end = stg[STAGES-1];

  // Only one start bit may be travelling at any time.
  assert_chain_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stg));

  // The strobe never lasts longer than one cycle.
  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);

endmodule

// File: rtl/rx_ctrl_fsm.sv
module rx_ctrl_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic line_q,
  input  logic near_end,
  output logic is_idle
);
  import start_framed_rx_pkg::*;

  rx_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RX_IDLE: if (line_q)   state_d = RX_BUSY;
      RX_BUSY: if (near_end) state_d = RX_IDLE;
      default:               state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= RX_IDLE;
    else        state_q <= state_d;
  end

  assign is_idle = (state_q == RX_IDLE);

  // The controller only leaves idle on a sampled start bit.
  assert_busy_from_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(is_idle) |-> $past(line_q));

  // The look-ahead tap hands control back in time for an adjoining start bit.
  assert_lookahead_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    near_end |=> is_idle);

endmodule

// File: rtl/rx_data_shift.sv
module rx_data_shift #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 line_q,
  output logic [DATA_BITS-1:0] word
);

  // Runs every cycle with no reset: a whole frame flushes it before use.
  always_ff @(posedge clk) begin
    word <= {line_q, word[DATA_BITS-1:1]};
  end

endmodule

// File: rtl/start_framed_rx.sv
module start_framed_rx #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 serial_in,
  output logic [DATA_BITS-1:0] byte_out,
  output logic                 byte_valid
);

  logic line_q;
  logic is_idle;
  logic near_end;
  logic frame_end;
  logic inject;

  rx_line_reg u_line (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (serial_in),
    .line_q  (line_q)
  );

  rx_ctrl_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_q   (line_q),
    .near_end (near_end),
    .is_idle  (is_idle)
  );

  // Masked entry: data bits seen while busy cannot enter the delay line.
  assign inject = line_q & is_idle;

  rx_frame_delay #(.DATA_BITS(DATA_BITS)) u_delay (
    .clk       (clk),
    .rst_n     (rst_n),
    .inject    (inject),
    .near_end  (near_end),
    .frame_end (frame_end)
  );

  rx_data_shift #(.DATA_BITS(DATA_BITS)) u_shift (
    .clk    (clk),
    .line_q (line_q),
    .word   (byte_out)
  );

  assign byte_valid = frame_end;

  // A strobe always closes a frame the controller was busy with.
  assert_strobe_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(!is_idle));

  // Synchronous reset clears the strobe on the next cycle.
  assert_reset_clears_R6: assert property (@(posedge clk)
    !rst_n |=> !byte_valid);

endmodule

// File: tb/start_framed_rx_tb.sv
`timescale 1ns/1ps
module start_framed_rx_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       serial_in = 1'b0;
  logic [7:0] byte_out;
  logic       byte_valid;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  start_framed_rx u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .serial_in  (serial_in),
    .byte_out   (byte_out),
    .byte_valid (byte_valid)
  );

  typedef struct packed {
    logic [7:0] data;
    logic [3:0] gap;   // idle zeros placed before the start bit
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VEC [NVEC] = '{
    '{8'hA5, 4'd3}, '{8'hFF, 4'd0}, '{8'h00, 4'd0},
    '{8'h01, 4'd2}, '{8'h80, 4'd0}, '{8'h3C, 4'd5},
    '{8'hFF, 4'd0}, '{8'hFF, 4'd0}, '{8'h6B, 4'd1}
  };

  logic       bits    [0:255];
  logic       exp_rdy [0:299];
  logic [7:0] exp_byt [0:299];
  int         len;

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input int cycles);
    @(negedge clk);
    rst_n = 1'b0;
    serial_in = 1'b0;
    repeat (cycles) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Watchdog
  initial begin
    #400000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int strobes;
    int last_edge;
    int busy_until;

    // Reset state (R6)
    do_reset(3);
    check("R6", byte_valid, 0, "byte_valid after reset");

    // Quiet line never strobes (R1)
    begin
      int seen = 0;
      repeat (20) begin
        @(negedge clk);
        if (byte_valid) seen++;
      end
      check("R1", seen, 0, "strobes on idle line");
    end

    // Build the vector stream
    len = 0;
    for (int v = 0; v < NVEC; v++) begin
      for (int g = 0; g < int'(VEC[v].gap); g++) begin bits[len] = 1'b0; len++; end
      bits[len] = 1'b1; len++;
      for (int b = 0; b < 8; b++) begin bits[len] = VEC[v].data[b]; len++; end
    end
    for (int k = 0; k < 14; k++) begin bits[len] = 1'b0; len++; end

    // Reference: start seen on edge j -> strobe after edge j+9, byte from j+1..j+8
    for (int e = 0; e < 300; e++) begin exp_rdy[e] = 1'b0; exp_byt[e] = 8'h00; end
    busy_until = -1;
    for (int j = 0; j < len; j++) begin
      if (j > busy_until && bits[j]) begin
        exp_rdy[j+9] = 1'b1;
        for (int b = 0; b < 8; b++) exp_byt[j+9][b] = bits[j+1+b];
        busy_until = j + 8;
      end
    end

    // Vector walk: edge i samples bits[i]; outputs checked half a cycle after
    strobes = 0;
    last_edge = -100;
    for (int i = 0; i <= len; i++) begin
      @(negedge clk);
      if (i >= 1) begin
        if (exp_rdy[i-1]) begin
          check("R3", byte_valid, 1, $sformatf("strobe after edge %0d", i-1));
          check("R2", byte_out, exp_byt[i-1], $sformatf("byte after edge %0d", i-1));
          if (last_edge >= 0 && (i-1) - last_edge < 10)
            check("R5", (i-1) - last_edge, 9, "back-to-back spacing");
          last_edge = i - 1;
          strobes++;
        end else if (byte_valid) begin
          check("R4", byte_valid, 0, $sformatf("spurious strobe after edge %0d", i-1));
        end
      end
      if (i < len) serial_in = bits[i];
    end
    check("R5", strobes, NVEC, "frames received in vector walk");

    // Single-cycle strobe (R7): one frame of all ones, count high cycles
    begin
      int hi = 0;
      int run = 0;
      int maxrun = 0;
      @(negedge clk);
      serial_in = 1'b1;
      repeat (8) @(negedge clk);
      serial_in = 1'b0;
      repeat (16) begin
        @(negedge clk);
        if (byte_valid) begin hi++; run++; end else run = 0;
        if (run > maxrun) maxrun = run;
      end
      check("R7", hi, 1, "strobe cycles for one frame");
      check("R7", maxrun, 1, "longest strobe run");
    end

    // Reset mid-frame aborts it (R6)
    begin
      int seen = 0;
      @(negedge clk);
      serial_in = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b0;
      serial_in = 1'b0;
      @(negedge clk);
      check("R6", byte_valid, 0, "strobe during reset");
      @(negedge clk);
      rst_n = 1'b1;
      repeat (15) begin
        @(negedge clk);
        if (byte_valid) seen++;
      end
      check("R6", seen, 0, "strobes after aborted frame");
    end

    // Fresh frame works after the abort (R1, R2)
    begin
      logic [7:0] pat = 8'hC3;
      int got = 0;
      logic [7:0] val = 8'h00;
      @(negedge clk);
      serial_in = 1'b1;
      for (int b = 0; b < 8; b++) begin
        @(negedge clk);
        serial_in = pat[b];
      end
      @(negedge clk);
      serial_in = 1'b0;
      repeat (4) begin
        @(negedge clk);
        if (byte_valid) begin got++; val = byte_out; end
      end
      check("R1", got, 1, "frame after reset recovery");
      check("R2", val, pat, "byte after reset recovery");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule